// File: doc/BRIEF.md
# Single-Wire Bus Slave Reset and Slot Timer

This block is the physical layer of a slave on a single open-drain, bidirectional data line. It samples the line with a free-running clock through a synchronizer and measures how long each low phase lasts. A long low is taken as a bus reset. The slave answers it, after a short wait, with a presence pulse of fixed length. Shorter lows are time slots. A falling edge opens a slot. In a receive slot the line level at a fixed sample point gives the bit. In a transmit slot the block either holds the line low, which sends a zero, or leaves it alone, which sends a one.

A speed input picks the standard timing set or the faster overdrive set. Each set has its own reset threshold, write sample point, presence wait, presence length and read-zero hold. All of them are parameters in microseconds, scaled by a ticks-per-microsecond parameter. Bits to send come through a valid/take handshake. The upper layer keeps a bit offered until the block takes it at the start of a slot. Received bits leave as a one-cycle strobe with data. A reset leaves as its own strobe. The only line output is a pull-low enable for the external open-drain driver.

Top module: `swb_slave_phy`

## Requirements
- R1: Out of reset, pull_low, rx_stb, rst_stb and tx_take are all 0, and the line is treated as released (high).
- R2: A line low that reaches the reset threshold (400 us standard, 40 us overdrive) and is then released gives a single rst_stb pulse, seen 3 clock cycles after the release.
- R3: A low shorter than the reset threshold gives no rst_stb. With no bit offered, it is decoded as a received 0.
- R4: The presence pulse starts exactly PWAIT cycles after rst_stb (30 us standard, 3 us overdrive). This falls inside the 15–60 us (standard) or 2–6 us (overdrive) window after the release.
- R5: The presence pulse lasts exactly PLOW cycles (120 us standard, 12 us overdrive). It covers the master's sample window of 60–75 us (standard) or 6–10 us (overdrive) after the release.
- R6: In a receive slot, rx_bit is 1 when the low lasted at most the sample point (37 us standard, 4 us overdrive) and 0 otherwise. Lows of 1–15 us (standard) or 1–2 us (overdrive) read as 1. Lows of 60 us or more (standard) or 6 us or more (overdrive) read as 0. Each slot gives exactly one rx_stb, at max(S+4, m+3) cycles after the falling edge, where S is the sample point and m is the low length, both in cycles.
- R7: When tx_valid is high at a falling edge, tx_take pulses once, 3 cycles after the edge. For tx_bit = 0 the line is held low through the master's read sample point (15 us standard, 2 us overdrive). It is released before 60 us (standard) or 7 us (overdrive).
- R8: In a transmit slot with tx_bit = 1, pull_low stays 0 and the line reads high at the master's sample point. A transmit slot produces no rx_stb.
- R9: A low that reaches the reset threshold overrides any slot in progress, even while the block itself drives a read-zero. Reset handling and presence follow, and the slot gives no rx_stb.
- R10: pull_low rises only at the start of a read-zero drive (together with tx_take) or of a presence pulse. Receive slots never drive the line.
- R11: od_sel = 1 applies the overdrive timing set to reset, presence, sampling and read hold. od_sel = 0 applies the standard set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_in | input | 1 | Raw line level (1 = released) |
| od_sel | input | 1 | 1 selects overdrive timing, 0 standard |
| tx_valid | input | 1 | A bit to transmit is offered |
| tx_bit | input | 1 | Bit value to transmit |
| tx_take | output | 1 | One-cycle pulse: offered bit taken for this slot |
| rx_stb | output | 1 | One-cycle pulse: received bit valid |
| rx_bit | output | 1 | Received bit value |
| rst_stb | output | 1 | One-cycle pulse: bus reset detected at release |
| pull_low | output | 1 | Enable for the external pull-low driver |

## Verification
Every result lands a fixed number of cycles after a line edge, because the synchronizer adds two cycles and the state register one more. tx_take comes 3 cycles after the falling edge. rst_stb comes 3 cycles after the release. The presence pulse starts PWAIT cycles after rst_stb and lasts PLOW cycles. rx_stb comes at max(S+4, m+3) cycles after the falling edge. The bench drives the line just after a falling clock edge and stamps every output event with a negative-edge cycle count, so each check compares a stamp difference against these formulas, computed from its own timing constants. Line levels seen by the master are checked at the microsecond points where a real master would sample.

// File: rtl/swb_pkg.sv
package swb_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_RXEND,
      ST_TX0,
      ST_WAITHI,
      ST_RSTLOW,
      ST_PWAIT,
      ST_PLOW
   } swb_state_e;

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/swb_sync.sv
module swb_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   logic [STAGES-1:0] q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q[i] <= RST_VAL;
            else        q[i] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q[i] <= RST_VAL;
            else        q[i] <= q[i-1];
         end
      end
   end

   assign dout = q[STAGES-1];

endmodule

// File: rtl/swb_window_sel.sv
module swb_window_sel #(
   parameter int unsigned CW        = 11,
   parameter int unsigned STD_RST   = 1600,
   parameter int unsigned OD_RST    = 160,
   parameter int unsigned STD_SAMP  = 148,
   parameter int unsigned OD_SAMP   = 16,
   parameter int unsigned STD_PWAIT = 120,
   parameter int unsigned OD_PWAIT  = 12,
   parameter int unsigned STD_PLOW  = 480,
   parameter int unsigned OD_PLOW   = 48,
   parameter int unsigned STD_HOLD  = 120,
   parameter int unsigned OD_HOLD   = 12
) (
   input  logic          od,
   output logic [CW-1:0] lim_rst,
   output logic [CW-1:0] lim_samp,
   output logic [CW-1:0] lim_pwait,
   output logic [CW-1:0] lim_plow,
   output logic [CW-1:0] lim_hold
);

   assign lim_rst   = od ? CW'(OD_RST)   : CW'(STD_RST);
   assign lim_samp  = od ? CW'(OD_SAMP)  : CW'(STD_SAMP);
   assign lim_pwait = od ? CW'(OD_PWAIT) : CW'(STD_PWAIT);
   assign lim_plow  = od ? CW'(OD_PLOW)  : CW'(STD_PLOW);
   assign lim_hold  = od ? CW'(OD_HOLD)  : CW'(STD_HOLD);

endmodule

// File: rtl/swb_low_timer.sv
module swb_low_timer #(
   parameter int unsigned CW = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          line,
   input  logic [CW-1:0] thr,
   output logic          long_low
);

   logic [CW-1:0] lowcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              lowcnt <= '0;
      else if (line)           lowcnt <= '0;
      else if (lowcnt != '1)   lowcnt <= lowcnt + CW'(1);
   end

   assign long_low = (lowcnt >= thr);

   // counter restarts on every released sample
   assert_low_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(line) |-> (lowcnt == '0));

endmodule

// File: rtl/swb_slave_phy.sv
module swb_slave_phy
   import swb_pkg::*;
#(
   parameter int unsigned TICKS_PER_US = 4,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter int unsigned STD_RST_US   = 400,
   parameter int unsigned OD_RST_US    = 40,
   parameter int unsigned STD_SAMP_US  = 37,
   parameter int unsigned OD_SAMP_US   = 4,
   parameter int unsigned STD_PWAIT_US = 30,
   parameter int unsigned OD_PWAIT_US  = 3,
   parameter int unsigned STD_PLOW_US  = 120,
   parameter int unsigned OD_PLOW_US   = 12,
   parameter int unsigned STD_HOLD_US  = 30,
   parameter int unsigned OD_HOLD_US   = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bus_in,
   input  logic od_sel,
   input  logic tx_valid,
   input  logic tx_bit,
   output logic tx_take,
   output logic rx_stb,
   output logic rx_bit,
   output logic rst_stb,
   output logic pull_low
);

   localparam int unsigned C_RST_S   = STD_RST_US   * TICKS_PER_US;
   localparam int unsigned C_RST_O   = OD_RST_US    * TICKS_PER_US;
   localparam int unsigned C_SAMP_S  = STD_SAMP_US  * TICKS_PER_US;
   localparam int unsigned C_SAMP_O  = OD_SAMP_US   * TICKS_PER_US;
   localparam int unsigned C_PWAIT_S = STD_PWAIT_US * TICKS_PER_US;
   localparam int unsigned C_PWAIT_O = OD_PWAIT_US  * TICKS_PER_US;
   localparam int unsigned C_PLOW_S  = STD_PLOW_US  * TICKS_PER_US;
   localparam int unsigned C_PLOW_O  = OD_PLOW_US   * TICKS_PER_US;
   localparam int unsigned C_HOLD_S  = STD_HOLD_US  * TICKS_PER_US;
   localparam int unsigned C_HOLD_O  = OD_HOLD_US   * TICKS_PER_US;
   localparam int unsigned CMAX = umax(umax(umax(C_RST_S, C_RST_O), umax(C_SAMP_S, C_SAMP_O)),
                                       umax(umax(C_PWAIT_S, C_PWAIT_O),
                                            umax(umax(C_PLOW_S, C_PLOW_O), umax(C_HOLD_S, C_HOLD_O))));
   localparam int unsigned CW = $clog2(CMAX + 1);

   // elaboration-time parameter checks
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("synchronizer needs at least two stages");
   end
   if (TICKS_PER_US < 4) begin : g_bad_tick
      $error("clock too slow for overdrive slots");
   end
   if (STD_SAMP_US <= 15 || STD_SAMP_US >= 60 || OD_SAMP_US <= 2 || OD_SAMP_US >= 6) begin : g_bad_samp
      $error("write sample point must sit between write-one and write-zero lows");
   end
   if (STD_PWAIT_US < 15 || STD_PWAIT_US > 60 || OD_PWAIT_US < 2 || OD_PWAIT_US > 6) begin : g_bad_pwait
      $error("presence wait out of range");
   end
   if (STD_PLOW_US < 60 || STD_PLOW_US > 240 || OD_PLOW_US < 8 || OD_PLOW_US > 24 ||
       STD_PWAIT_US + STD_PLOW_US <= 75 || OD_PWAIT_US + OD_PLOW_US <= 10) begin : g_bad_plow
      $error("presence low must cover the master sample window");
   end
   if (STD_HOLD_US <= 15 || STD_HOLD_US >= 60 || OD_HOLD_US <= 2 || OD_HOLD_US >= 7) begin : g_bad_hold
      $error("read-zero hold must pass the master sample point and end inside the slot");
   end
   if (STD_RST_US >= 480 || STD_RST_US <= 120 || OD_RST_US >= 48 || OD_RST_US <= 16) begin : g_bad_rst
      $error("reset threshold must lie between slot lows and the minimum reset low");
   end

   logic          ln;
   logic          long_low;
   logic [CW-1:0] lim_rst, lim_samp, lim_pwait, lim_plow, lim_hold;

   swb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk (clk), .rst_n (rst_n), .din (bus_in), .dout (ln)
   );

   swb_window_sel #(
      .CW (CW),
      .STD_RST (C_RST_S),     .OD_RST (C_RST_O),
      .STD_SAMP (C_SAMP_S),   .OD_SAMP (C_SAMP_O),
      .STD_PWAIT (C_PWAIT_S), .OD_PWAIT (C_PWAIT_O),
      .STD_PLOW (C_PLOW_S),   .OD_PLOW (C_PLOW_O),
      .STD_HOLD (C_HOLD_S),   .OD_HOLD (C_HOLD_O)
   ) u_win (
      .od (od_sel), .lim_rst (lim_rst), .lim_samp (lim_samp),
      .lim_pwait (lim_pwait), .lim_plow (lim_plow), .lim_hold (lim_hold)
   );

   swb_low_timer #(.CW(CW)) u_low (
      .clk (clk), .rst_n (rst_n), .line (ln), .thr (lim_rst), .long_low (long_low)
   );

   swb_state_e    st, st_nxt;
   logic [CW-1:0] cnt, cnt_nxt;
   logic          bit_q, bit_nxt;
   logic          take_c, rxs_c, rsts_c;

   always_comb begin
      st_nxt  = st;
      cnt_nxt = cnt + CW'(1);
      bit_nxt = bit_q;
      take_c  = 1'b0;
      rxs_c   = 1'b0;
      rsts_c  = 1'b0;
      case (st)
         ST_IDLE: begin
            cnt_nxt = CW'(1);
            if (!ln) begin
               if (tx_valid) begin
                  take_c = 1'b1;
                  st_nxt = tx_bit ? ST_WAITHI : ST_TX0;
               end else begin
                  st_nxt = ST_RX;
               end
            end
         end
         ST_RX: begin
            if (cnt == lim_samp) begin
               bit_nxt = ln;
               st_nxt  = ST_RXEND;
            end
         end
         ST_RXEND: begin
            if (ln) begin
               rxs_c  = 1'b1;
               st_nxt = ST_IDLE;
            end
         end
         ST_TX0: begin
            if (cnt == lim_hold) st_nxt = ST_WAITHI;
         end
         ST_WAITHI: begin
            if (ln) st_nxt = ST_IDLE;
         end
         ST_RSTLOW: begin
            if (ln) begin
               rsts_c  = 1'b1;
               st_nxt  = ST_PWAIT;
               cnt_nxt = CW'(1);
            end
         end
         ST_PWAIT: begin
            if (cnt == lim_pwait) begin
               st_nxt  = ST_PLOW;
               cnt_nxt = CW'(1);
            end
         end
         ST_PLOW: begin
            if (cnt == lim_plow) st_nxt = ST_WAITHI;
         end
         default: st_nxt = ST_IDLE;
      endcase
      // an over-long low wins over any slot activity
      if (long_low && (st inside {ST_IDLE, ST_RX, ST_RXEND, ST_TX0, ST_WAITHI})) begin
         st_nxt = ST_RSTLOW;
         take_c = 1'b0;
         rxs_c  = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         cnt     <= '0;
         bit_q   <= 1'b0;
         tx_take <= 1'b0;
         rx_stb  <= 1'b0;
         rst_stb <= 1'b0;
      end else begin
         st      <= st_nxt;
         cnt     <= cnt_nxt;
         bit_q   <= bit_nxt;
         tx_take <= take_c;
         rx_stb  <= rxs_c;
         rst_stb <= rsts_c;
      end
   end

   assign rx_bit   = bit_q;
   assign pull_low = (st == ST_TX0) || (st == ST_PLOW);

   assert_take_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      tx_take |=> !tx_take);

   assert_take_offered_R7: assert property (@(posedge clk) disable iff (!rst_n)
      tx_take |-> $past(tx_valid));

   assert_rx_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_stb |=> !rx_stb);

   assert_rst_released_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rst_stb |-> !pull_low);

   assert_drive_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pull_low) |-> (tx_take || st == ST_PLOW));

   assert_rx_not_during_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_stb |-> !pull_low);

endmodule

// File: tb/test_swb_slave_phy.sv
module test_swb_slave_phy;

   localparam int TPU = 4;
   localparam int RST_S = 400, RST_O = 40;
   localparam int SAMP_S = 37, SAMP_O = 4;
   localparam int PW_S = 30, PW_O = 3;
   localparam int PL_S = 120, PL_O = 12;
   localparam int HD_S = 30, HD_O = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_low = 1'b0;
   logic od_sel = 1'b0;
   logic tx_valid = 1'b0;
   logic tx_bit = 1'b0;
   logic tx_take, rx_stb, rx_bit, rst_stb, pull_low;
   logic bus_in;

   assign bus_in = !(m_low || pull_low);

   always #2 clk = ~clk;

   swb_slave_phy #(
      .TICKS_PER_US (TPU), .SYNC_STAGES (2),
      .STD_RST_US (RST_S), .OD_RST_US (RST_O),
      .STD_SAMP_US (SAMP_S), .OD_SAMP_US (SAMP_O),
      .STD_PWAIT_US (PW_S), .OD_PWAIT_US (PW_O),
      .STD_PLOW_US (PL_S), .OD_PLOW_US (PL_O),
      .STD_HOLD_US (HD_S), .OD_HOLD_US (HD_O)
   ) i_swb_slave_phy (
      .clk (clk), .rst_n (rst_n), .bus_in (bus_in), .od_sel (od_sel),
      .tx_valid (tx_valid), .tx_bit (tx_bit), .tx_take (tx_take),
      .rx_stb (rx_stb), .rx_bit (rx_bit), .rst_stb (rst_stb), .pull_low (pull_low)
   );

   int total = 0, bad = 0;
   int cyc = 0;
   int rx_cnt = 0, rx_at = 0, rx_last = 0;
   int rst_cnt = 0, rst_at = 0;
   int take_cnt = 0, take_at = 0;
   int rise_cnt = 0, rise_at = 0, fall_at = 0;
   logic pl_q = 1'b0;
   bit finished = 1'b0;

   always @(negedge clk) begin
      cyc = cyc + 1;
      if (rx_stb) begin rx_cnt++; rx_at = cyc; rx_last = int'(rx_bit); end
      if (rst_stb) begin rst_cnt++; rst_at = cyc; end
      if (tx_take) begin take_cnt++; take_at = cyc; end
      if (pull_low && !pl_q) begin rise_cnt++; rise_at = cyc; end
      if (!pull_low && pl_q) fall_at = cyc;
      pl_q = pull_low;
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   // master holds the line low for ncyc cycles
   task automatic pulse(input int ncyc, output int t_fall, output int t_rel);
      tick(1);
      m_low = 1'b1;
      t_fall = cyc;
      tick(ncyc);
      m_low = 1'b0;
      t_rel = cyc;
   endtask

   // R6 R11: receive slot of low_us microseconds
   task automatic wslot(input bit od, input int low_us);
      int s, m, tf, tr, rx0, ri0, exp_lat;
      int exp_bit;
      od_sel = od;
      s = (od ? SAMP_O : SAMP_S) * TPU;
      m = low_us * TPU;
      rx0 = rx_cnt; ri0 = rise_cnt;
      pulse(m, tf, tr);
      tick(s + 20);
      exp_bit = (m <= s) ? 1 : 0;
      exp_lat = (s + 4 > m + 3) ? s + 4 : m + 3;
      chk(rx_cnt == rx0 + 1, "R6 one strobe per slot", rx_cnt - rx0, 1);
      chk(rx_last == exp_bit, "R6 decoded bit", rx_last, exp_bit);
      chk(rx_at - tf == exp_lat, "R6 strobe latency", rx_at - tf, exp_lat);
      chk(rise_cnt == ri0, "R10 no drive in receive slot", rise_cnt - ri0, 0);
   endtask

   // R2 R4 R5 R3: reset-length low
   task automatic rslot(input bit od, input int low_us, input bit expect_rst);
      int w, l, tf, tr, r0, x0, d;
      od_sel = od;
      w = (od ? PW_O : PW_S) * TPU;
      l = (od ? PL_O : PL_S) * TPU;
      r0 = rst_cnt; x0 = rx_cnt;
      pulse(low_us * TPU, tf, tr);
      tick(w + l + 30);
      if (expect_rst) begin
         chk(rst_cnt == r0 + 1, "R2 reset strobe count", rst_cnt - r0, 1);
         chk(rst_at - tr == 3, "R2 reset strobe latency", rst_at - tr, 3);
         chk(rise_at - rst_at == w, "R4 presence wait", rise_at - rst_at, w);
         d = rise_at - tr;
         chk(d >= (od ? 2 : 15) * TPU && d <= (od ? 6 : 60) * TPU, "R4 presence start window", d, (od ? 2 : 15) * TPU);
         chk(fall_at - rise_at == l, "R5 presence length", fall_at - rise_at, l);
         chk(d + l > (od ? 10 : 75) * TPU, "R5 covers master sample window", d + l, (od ? 10 : 75) * TPU);
         chk(rx_cnt == x0, "R9 no bit from reset low", rx_cnt - x0, 0);
      end else begin
         chk(rst_cnt == r0, "R3 no reset below threshold", rst_cnt - r0, 0);
         chk(rx_cnt == x0 + 1 && rx_last == 0, "R3 short low read as zero", rx_last, 0);
      end
   endtask

   // R7 R8: transmit slot
   task automatic tslot(input bit od, input bit b);
      int tf, t0, ri0, x0, smp, rel;
      od_sel = od;
      smp = (od ? 2 : 15) * TPU;
      rel = (od ? 7 : 60) * TPU;
      t0 = take_cnt; ri0 = rise_cnt; x0 = rx_cnt;
      tx_valid = 1'b1; tx_bit = b;
      tick(1);
      m_low = 1'b1;
      tf = cyc;
      tick(TPU);
      m_low = 1'b0;
      tick(smp - TPU);
      chk(bus_in == b, b ? "R8 line high at master sample" : "R7 line low at master sample", int'(bus_in), int'(b));
      tick(rel - smp);
      chk(bus_in == 1'b1, "R7 line released before slot end", int'(bus_in), 1);
      chk(take_cnt == t0 + 1, "R7 one take per slot", take_cnt - t0, 1);
      chk(take_at - tf == 3, "R7 take latency", take_at - tf, 3);
      chk(rise_cnt == ri0 + (b ? 0 : 1), b ? "R8 no drive for one" : "R10 drive for zero", rise_cnt - ri0, b ? 0 : 1);
      chk(rx_cnt == x0, "R8 no receive strobe in transmit slot", rx_cnt - x0, 0);
      tx_valid = 1'b0;
      tick(10 * TPU);
   endtask

   initial begin
      tick(3);
      chk(pull_low == 0 && rx_stb == 0 && rst_stb == 0 && tx_take == 0, "R1 outputs idle in reset",
          int'(pull_low) + int'(rx_stb) + int'(rst_stb) + int'(tx_take), 0);
      rst_n = 1'b1;
      tick(5);
      chk(pull_low == 0 && rx_cnt == 0 && rst_cnt == 0 && take_cnt == 0, "R1 idle after reset",
          rx_cnt + rst_cnt + take_cnt, 0);

      // R2 R4 R5 standard and overdrive resets (R11)
      rslot(1'b0, 480, 1'b1);
      rslot(1'b1, 60, 1'b1);
      // R3 below threshold
      rslot(1'b0, 300, 1'b0);
      rslot(1'b1, 30, 1'b0);

      // R6 standard sweep
      for (int w = 1; w <= 15; w++) wslot(1'b0, w);
      for (int w = 60; w <= 120; w += 10) wslot(1'b0, w);
      // R6 R11 overdrive sweep
      for (int w = 1; w <= 2; w++) wslot(1'b1, w);
      for (int w = 6; w <= 15; w++) wslot(1'b1, w);

      // R7 R8 transmit slots both speeds
      tslot(1'b0, 1'b0);
      tslot(1'b0, 1'b1);
      tslot(1'b1, 1'b0);
      tslot(1'b1, 1'b1);

      // R9 reset overrides a read-zero drive in progress
      begin
         int tf, tr, r0, t0, x0;
         od_sel = 1'b0;
         r0 = rst_cnt; t0 = take_cnt; x0 = rx_cnt;
         tx_valid = 1'b1; tx_bit = 1'b0;
         pulse(480 * TPU, tf, tr);
         tx_valid = 1'b0;
         tick((PW_S + PL_S) * TPU + 30);
         chk(take_cnt == t0 + 1, "R9 slot started before reset", take_cnt - t0, 1);
         chk(rst_cnt == r0 + 1, "R9 reset detected over slot", rst_cnt - r0, 1);
         chk(rst_at - tr == 3, "R9 reset latency", rst_at - tr, 3);
         chk(fall_at - rise_at == PL_S * TPU, "R9 presence follows", fall_at - rise_at, PL_S * TPU);
         chk(rx_cnt == x0, "R9 no receive strobe", rx_cnt - x0, 0);
      end

      // R6 slot still decodes after the override
      wslot(1'b0, 5);

      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog act=%0d exp=%0d", cyc, 200000);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule